// File: doc/BRIEF.md
# Dual-Write Register File with Same-Cycle Bypass

This block holds the general-purpose registers of a five-stage in-order pipeline. The decode stage reads source operands through two read ports. The write-back stage commits results through two write ports. One write port carries execution results and the other carries data returned by memory loads. Both write ports can commit in the same clock edge.

A read port whose address matches a write that is active in the current cycle returns the incoming value instead of the stored one. Decode therefore sees a result in the same cycle that write-back produces it. Reads are combinational and writes commit on the rising clock edge.

When both write ports target the same register in one cycle, the load data wins. This applies to the stored value and to the bypassed value. Hazard detection, stalling and execution-stage forwarding belong to other blocks.

Top module: `dual_wb_regfile`

## Requirements
- R1: The file holds 16 registers of 32 bits (parameters NUM_REGS and DATA_W). A value committed at a rising edge is returned by either read port in later cycles, as long as no write to that register is active.
- R2: A synchronous active-high reset clears every register to zero. While reset is high, writes on either port are not committed.
- R3: When the result write port is enabled and its address equals a read address, and no load write targets the same register, that read port returns the result write data in the same cycle.
- R4: When the load write port is enabled and its address equals a read address, that read port returns the load write data in the same cycle.
- R5: When both write ports are enabled with different addresses in one cycle, both registers are updated at that edge.
- R6: When both write ports are enabled with equal addresses, the register keeps the load data and the same-cycle read of it returns the load data.
- R7: Register 0 is ordinary storage: it can be written and read back, and it is not forced to zero.
- R8: With a write enable low, that port's address and data have no effect on any register.
- R9: The two read ports are independent. Equal read addresses return equal data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| aluWrEn | input | 1 | Result write enable |
| aluWrAddr | input | 4 | Result write register index |
| aluWrData | input | 32 | Result write data |
| ldWrEn | input | 1 | Load write enable |
| ldWrAddr | input | 4 | Load write register index |
| ldWrData | input | 32 | Load write data |
| rdAddrA | input | 4 | Read port A register index |
| rdDataA | output | 32 | Read port A data, bypassed |
| rdAddrB | input | 4 | Read port B register index |
| rdDataB | output | 32 | Read port B data, bypassed |

## Verification
The bench builds the block with its default sixteen registers of 32 bits. At that size it can sweep all 256 ordered pairs of load and result write addresses with both ports enabled. The sweep covers every same-register conflict, including register 0, and every different-register double commit. Each read is compared with a reference array that the bench updates with the load-wins rule, and the write data is derived arithmetically from the address pair.

// File: rtl/rf_types_pkg.sv
package rf_types_pkg;

  // Source chosen for one read port
  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_ALU   = 2'd1,
    SRC_LOAD  = 2'd2
  } rdSrc_e;

  // Write strobes passed from control to datapath
  typedef struct packed {
    logic clearAll;
    logic aluCommit;
    logic ldCommit;
  } wrStrobe_t;

endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_types_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_RD = 2
) (
  input  logic                           rst,
  input  logic                           aluWrEn,
  input  logic [ADDR_W-1:0]              aluWrAddr,
  input  logic                           ldWrEn,
  input  logic [ADDR_W-1:0]              ldWrAddr,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rdAddr,
  output wrStrobe_t                      strobe,
  output rdSrc_e                         rdSel [NUM_RD]
);

  logic sameDest;

  // Load port wins a same-register conflict; reset beats both writes
  always_comb begin
    sameDest         = aluWrEn && ldWrEn && (aluWrAddr == ldWrAddr);
    strobe.clearAll  = rst;
    strobe.aluCommit = aluWrEn && !sameDest && !rst;
    strobe.ldCommit  = ldWrEn && !rst;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_sel
    always_comb begin
      if (ldWrEn && (ldWrAddr == rdAddr[p]))
        rdSel[p] = SRC_LOAD;
      else if (aluWrEn && (aluWrAddr == rdAddr[p]))
        rdSel[p] = SRC_ALU;
      else
        rdSel[p] = SRC_ARRAY;
    end
  end

endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_types_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_RD   = 2,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  wrStrobe_t                      strobe,
  input  logic [ADDR_W-1:0]              aluWrAddr,
  input  logic [DATA_W-1:0]              aluWrData,
  input  logic [ADDR_W-1:0]              ldWrAddr,
  input  logic [DATA_W-1:0]              ldWrData,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rdAddr,
  input  rdSrc_e                         rdSel [NUM_RD],
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  // Control never raises both commits for one register
  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      if (strobe.aluCommit) regs[aluWrAddr] <= aluWrData;
      if (strobe.ldCommit)  regs[ldWrAddr]  <= ldWrData;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      unique case (rdSel[p])
        SRC_LOAD: rdData[p] = ldWrData;
        SRC_ALU:  rdData[p] = aluWrData;
        default:  rdData[p] = regs[rdAddr[p]];
      endcase
    end
  end

endmodule

// File: rtl/dual_wb_regfile.sv
module dual_wb_regfile
  import rf_types_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aluWrEn,
  input  logic [ADDR_W-1:0] aluWrAddr,
  input  logic [DATA_W-1:0] aluWrData,
  input  logic              ldWrEn,
  input  logic [ADDR_W-1:0] ldWrAddr,
  input  logic [DATA_W-1:0] ldWrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB
);

  localparam int NUM_RD = 2;

  wrStrobe_t                     strobe;
  rdSrc_e                        rdSel [NUM_RD];
  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr;
  logic [NUM_RD-1:0][DATA_W-1:0] rdData;

  assign rdAddr  = {rdAddrB, rdAddrA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  rf_ctrl #(.ADDR_W(ADDR_W), .NUM_RD(NUM_RD)) uCtrl (
    .rst       (rst),
    .aluWrEn   (aluWrEn),
    .aluWrAddr (aluWrAddr),
    .ldWrEn    (ldWrEn),
    .ldWrAddr  (ldWrAddr),
    .rdAddr    (rdAddr),
    .strobe    (strobe),
    .rdSel     (rdSel)
  );

  rf_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) uDp (
    .clk       (clk),
    .strobe    (strobe),
    .aluWrAddr (aluWrAddr),
    .aluWrData (aluWrData),
    .ldWrAddr  (ldWrAddr),
    .ldWrData  (ldWrData),
    .rdAddr    (rdAddr),
    .rdSel     (rdSel),
    .rdData    (rdData)
  );

endmodule

// File: rtl/dual_wb_regfile_chk.sv
module dual_wb_regfile_chk #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              aluWrEn,
  input logic [ADDR_W-1:0] aluWrAddr,
  input logic [DATA_W-1:0] aluWrData,
  input logic              ldWrEn,
  input logic [ADDR_W-1:0] ldWrAddr,
  input logic [DATA_W-1:0] ldWrData,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataB
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  logic hitA;
  logic hitB;
  assign hitA = (aluWrEn && aluWrAddr == rdAddrA) || (ldWrEn && ldWrAddr == rdAddrA);
  assign hitB = (aluWrEn && aluWrAddr == rdAddrB) || (ldWrEn && ldWrAddr == rdAddrB);

  // R4: load write forwarded on both ports
  assert_ld_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    (ldWrEn && ldWrAddr == rdAddrA) |-> rdDataA == ldWrData);
  assert_ld_bypass_b_R4: assert property (@(posedge clk) disable iff (rst)
    (ldWrEn && ldWrAddr == rdAddrB) |-> rdDataB == ldWrData);

  // R3: result write forwarded when no load targets it
  assert_alu_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    (aluWrEn && aluWrAddr == rdAddrA && !(ldWrEn && ldWrAddr == aluWrAddr))
      |-> rdDataA == aluWrData);

  // R6: on a conflict the stored value is the load data
  assert_conflict_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(aluWrEn) && $past(ldWrEn) && $past(aluWrAddr) == $past(ldWrAddr)
      && rdAddrA == $past(ldWrAddr) && !hitA) |-> rdDataA == $past(ldWrData));

  // R1: a committed load value is readable next cycle
  assert_load_persists_R1: assert property (@(posedge clk) disable iff (rst)
    (started && !$past(rst) && $past(ldWrEn) && rdAddrB == $past(ldWrAddr) && !hitB)
      |-> rdDataB == $past(ldWrData));

  // R2: just after reset every unbypassed read is zero
  assert_reset_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (started && $past(rst) && !hitA) |-> rdDataA == '0);

  // R9: equal read addresses give equal data
  assert_ports_agree_R9: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == rdAddrB) |-> rdDataA == rdDataB);

endmodule

bind dual_wb_regfile dual_wb_regfile_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .aluWrEn   (aluWrEn),
  .aluWrAddr (aluWrAddr),
  .aluWrData (aluWrData),
  .ldWrEn    (ldWrEn),
  .ldWrAddr  (ldWrAddr),
  .ldWrData  (ldWrData),
  .rdAddrA   (rdAddrA),
  .rdDataA   (rdDataA),
  .rdAddrB   (rdAddrB),
  .rdDataB   (rdDataB)
);

// File: tb/sim_dual_wb_regfile.sv
`timescale 1ns/1ps
module sim_dual_wb_regfile;

  localparam int NR = 16;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          aluWrEn = 1'b0;
  logic [AW-1:0] aluWrAddr = '0;
  logic [DW-1:0] aluWrData = '0;
  logic          ldWrEn = 1'b0;
  logic [AW-1:0] ldWrAddr = '0;
  logic [DW-1:0] ldWrData = '0;
  logic [AW-1:0] rdAddrA = '0;
  logic [AW-1:0] rdAddrB = '0;
  logic [DW-1:0] rdDataA;
  logic [DW-1:0] rdDataB;

  always #2.5 clk = ~clk;

  dual_wb_regfile u0 (
    .clk(clk), .rst(rst),
    .aluWrEn(aluWrEn), .aluWrAddr(aluWrAddr), .aluWrData(aluWrData),
    .ldWrEn(ldWrEn), .ldWrAddr(ldWrAddr), .ldWrData(ldWrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cycles = 0;
  logic [DW-1:0] ref_q [NR];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    aluWrEn = 1'b0;
    ldWrEn  = 1'b0;
  endtask

  // Read every register on both ports with writes idle
  task automatic sweepAll(input string req);
    idle();
    for (int r = 0; r < NR; r++) begin
      rdAddrA = AW'(r);
      rdAddrB = AW'(NR - 1 - r);
      #0.2;
      chk(req, rdDataA, ref_q[r]);
      chk(req, rdDataB, ref_q[NR - 1 - r]);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) ref_q[i] = '0;

    // R2: reset with a write pending; the write must not land
    aluWrEn = 1'b1; aluWrAddr = 4'd5; aluWrData = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle();
    rst = 1'b0;
    sweepAll("R2 reset clear");

    // R3 and R7: fill each register through the result port, register 0 included
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      aluWrEn = 1'b1; aluWrAddr = AW'(i); aluWrData = 32'hA000_0000 + DW'(i) * 32'h111;
      rdAddrA = AW'(i);
      #0.2;
      chk("R3 alu bypass", rdDataA, 32'hA000_0000 + DW'(i) * 32'h111);
      @(posedge clk);
      ref_q[i] = 32'hA000_0000 + DW'(i) * 32'h111;
    end
    @(negedge clk);
    sweepAll("R1 R7 readback");
    chk("R7 reg0 nonzero", ref_q[0] == 0 ? 32'h1 : 32'h0, 32'h0);

    // R8: disabled ports carry junk for a few cycles
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      idle();
      aluWrAddr = AW'(k); aluWrData = 32'h0BAD_0000 + DW'(k);
      ldWrAddr  = AW'(k + 4); ldWrData = 32'h0BAD_1000 + DW'(k);
      @(posedge clk);
    end
    @(negedge clk);
    sweepAll("R8 disabled ignored");

    // R4 R5 R6: every ordered pair of load and result addresses
    for (int l = 0; l < NR; l++) begin
      for (int a = 0; a < NR; a++) begin
        @(negedge clk);
        ldWrEn = 1'b1;  ldWrAddr = AW'(l);  ldWrData = 32'h5000_0000 | DW'(l << 8) | DW'(a);
        aluWrEn = 1'b1; aluWrAddr = AW'(a); aluWrData = 32'h3000_0000 | DW'(a << 12) | DW'(l << 4);
        rdAddrA = AW'(l);
        rdAddrB = AW'(a);
        #0.2;
        chk("R4 load bypass", rdDataA, ldWrData);
        chk(l == a ? "R6 conflict bypass" : "R3 alu bypass dual", rdDataB,
            l == a ? ldWrData : aluWrData);
        @(posedge clk);
        ref_q[a] = aluWrData;
        ref_q[l] = ldWrData;
        #1;
        idle();
        #0.2;
        chk(l == a ? "R6 conflict stored" : "R5 dual commit load", rdDataA, ref_q[l]);
        chk(l == a ? "R6 conflict stored" : "R5 dual commit alu", rdDataB, ref_q[a]);
      end
    end
    @(negedge clk);
    sweepAll("R1 after sweep");

    // R9: same address on both ports
    for (int r = 0; r < NR; r++) begin
      rdAddrA = AW'(r);
      rdAddrB = AW'(r);
      #0.2;
      chk("R9 ports agree", rdDataA, rdDataB);
    end

    // R2: reset mid-run clears stored state
    @(negedge clk);
    rst = 1'b1;
    ldWrEn = 1'b1; ldWrAddr = 4'd3; ldWrData = 32'hFFFF_0003;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NR; i++) ref_q[i] = '0;
    sweepAll("R2 reset midrun");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule